// File: doc/BRIEF.md
# MII Transmit Path with Collision-Pause Control

This block drives the transmit half of a MAC-to-PHY Media Independent Interface. Frame bytes arrive on a valid/ready stream that marks the first and the last byte of each frame. Each byte leaves as two 4-bit nibbles on the PHY-supplied transmit clock, together with a transmit enable and a transmit error line. The logic is the same at 10 and 100 Mbps; only the frequency of the transmit clock changes.

A mode input selects full or half duplex. In full duplex the collision input is reused as a frame-granular pause. While it is high no new frame may begin, but a frame already on the wire always runs to its end. In half duplex the carrier-sense input defers the start of a frame while the medium is busy. Both inputs pass through a two-flop synchronizer. The pause or defer decision is taken only in the idle state, at the moment a frame would start. If the upstream stream runs dry in the middle of a frame, the block marks the rest of that frame as errored until the end-marked byte arrives.

Top module: `mii_tx_path`

## Requirements
- R1: While reset is asserted and after it is released, `tx_en`, `tx_er` and `tx_data` are all zero until a frame starts.
- R2: Each byte goes out as two consecutive nibbles, bits [3:0] first and then bits [7:4], with `tx_data[0]` the least significant bit. `tx_en` stays high without a break across a frame whose bytes are offered on time, and the block takes at most one frame byte every two cycles.
- R3: Whenever `tx_en` is low, `tx_data` is 4'b0000 and `tx_er` is low.
- R4: When the next start-marked byte is already waiting as a frame ends normally, `tx_en` is low for exactly one cycle between the two frames.
- R5: In full duplex, while the synchronized `col_async` is high, a start-marked byte is not accepted and no frame begins. A frame already in progress when `col_async` rises sends all of its nibbles without a break.
- R6: In full duplex with `col_async` held low, frames are never held back.
- R7: In half duplex, while the synchronized `crs_async` is high, no frame begins. After `crs_async` falls with a frame waiting, the first nibble appears on the third rising clock edge and not earlier.
- R8: In half duplex `col_async` has no effect on frame starts. In full duplex `crs_async` has no effect on frame starts.
- R9: If no byte is offered when the next byte of a frame is due, `tx_en` stays high with `tx_er` high and `tx_data` 4'b0000 on every cycle until a byte with `s_eof` high is accepted. Bytes accepted in that period are discarded, and `tx_en` then falls.
- R10: A byte offered while idle without `s_sof` is accepted and dropped, and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_tx | input | 1 | PHY-supplied transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_full_duplex | input | 1 | 1 = full duplex (collision acts as a pause), 0 = half duplex (carrier defers) |
| s_valid | input | 1 | Upstream byte is valid |
| s_ready | output | 1 | Block accepts the byte this cycle |
| s_data | input | 8 | Upstream byte |
| s_sof | input | 1 | Byte is the first of a frame |
| s_eof | input | 1 | Byte is the last of a frame |
| col_async | input | 1 | Collision / pause input from the PHY, asynchronous |
| crs_async | input | 1 | Carrier sense from the PHY, asynchronous |
| tx_data | output | 4 | Transmit nibble |
| tx_en | output | 1 | Transmit enable |
| tx_er | output | 1 | Transmit error |

## Verification
The assertions assume that the upstream source keeps `s_data`, `s_sof` and `s_eof` stable while `s_valid` is high and the byte has not yet been accepted. They also assume that every frame has exactly one start-marked first byte and ends with one end-marked byte. The bench keeps to this by driving each byte at the falling edge and holding it until a handshake has been seen. It moves `col_async`, `crs_async` and `cfg_full_duplex` only at falling edges. It changes the mode only while the line is idle. Underrun frames are built by leaving `s_valid` low for several cycles in the middle of a frame and then sending tail bytes that end with an end-marked byte.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_STARVE,
    ST_GAP
  } tx_state_e;

  typedef enum logic [2:0] {
    OP_QUIET,
    OP_FIRST,
    OP_HIGH,
    OP_HIGH_LOAD,
    OP_LOW,
    OP_ERR
  } nib_op_e;

  // Select one nibble of a byte: hi=0 gives bits [3:0], hi=1 gives [7:4].
  function automatic logic [NIB_W-1:0] nib_of(input logic [BYTE_W-1:0] b,
                                               input logic hi);
    return hi ? b[BYTE_W-1:NIB_W] : b[NIB_W-1:0];
  endfunction

  // Start-blocking input chosen by the duplex mode.
  function automatic logic hold_start(input logic full_dup,
                                      input logic col_s,
                                      input logic crs_s);
    return full_dup ? col_s : crs_s;
  endfunction
endpackage

// File: rtl/mii_tx_sync.sv
module mii_tx_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= '0;
        else        stage_q[i] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= '0;
        else        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/mii_tx_ctrl.sv
module mii_tx_ctrl
  import mii_tx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    hold,
  input  logic    s_valid,
  input  logic    s_sof,
  input  logic    s_eof,
  input  logic    line_en,
  output logic    s_ready,
  output nib_op_e op,
  output logic    start_fire,
  output logic    data_accept
);
  tx_state_e state_q, state_d;
  logic      phase_hi_q, phase_hi_d;
  logic      last_q, last_d;
  logic      accept;

  always_comb begin
    s_ready = 1'b0;
    unique case (state_q)
      ST_IDLE:   s_ready = s_sof ? !hold : 1'b1;
      ST_DATA:   s_ready = phase_hi_q && !last_q;
      ST_STARVE: s_ready = 1'b1;
      default:   s_ready = 1'b0;
    endcase
  end

  assign accept      = s_valid && s_ready;
  assign start_fire  = (state_q == ST_IDLE) && accept && s_sof;
  assign data_accept = (state_q == ST_DATA) && accept;

  always_comb begin
    state_d    = state_q;
    phase_hi_d = phase_hi_q;
    last_d     = last_q;
    op         = OP_QUIET;
    unique case (state_q)
      ST_IDLE: begin
        if (start_fire) begin
          state_d    = ST_DATA;
          phase_hi_d = 1'b1;
          last_d     = s_eof;
          op         = OP_FIRST;
        end
      end
      ST_DATA: begin
        if (!phase_hi_q) begin
          op         = OP_LOW;
          phase_hi_d = 1'b1;
        end else if (last_q) begin
          op      = OP_HIGH;
          state_d = ST_GAP;
        end else if (accept) begin
          op         = OP_HIGH_LOAD;
          phase_hi_d = 1'b0;
          last_d     = s_eof;
        end else begin
          op      = OP_HIGH;
          state_d = ST_STARVE;
        end
      end
      ST_STARVE: begin
        if (accept && s_eof) begin
          op      = OP_QUIET;
          state_d = ST_GAP;
        end else begin
          op = OP_ERR;
        end
      end
      default: begin
        op      = OP_QUIET;
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      phase_hi_q <= 1'b0;
      last_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      phase_hi_q <= phase_hi_d;
      last_q     <= last_d;
    end
  end

  // R2: a frame byte is never taken on two cycles in a row
  assert_byte_rate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    data_accept |=> !data_accept);

  // R4: a new frame only starts from a quiet line
  assert_gap_before_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire |-> !line_en);
endmodule

// File: rtl/mii_tx_nibble.sv
module mii_tx_nibble
  import mii_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  nib_op_e           op,
  input  logic [BYTE_W-1:0] in_byte,
  output logic [NIB_W-1:0]  tx_data,
  output logic              tx_en,
  output logic              tx_er
);
  logic [BYTE_W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      tx_data <= '0;
      tx_en   <= 1'b0;
      tx_er   <= 1'b0;
    end else begin
      unique case (op)
        OP_FIRST: begin
          hold_q  <= in_byte;
          tx_data <= nib_of(in_byte, 1'b0);
          tx_en   <= 1'b1;
          tx_er   <= 1'b0;
        end
        OP_HIGH: begin
          tx_data <= nib_of(hold_q, 1'b1);
          tx_en   <= 1'b1;
          tx_er   <= 1'b0;
        end
        OP_HIGH_LOAD: begin
          hold_q  <= in_byte;
          tx_data <= nib_of(hold_q, 1'b1);
          tx_en   <= 1'b1;
          tx_er   <= 1'b0;
        end
        OP_LOW: begin
          tx_data <= nib_of(hold_q, 1'b0);
          tx_en   <= 1'b1;
          tx_er   <= 1'b0;
        end
        OP_ERR: begin
          tx_data <= '0;
          tx_en   <= 1'b1;
          tx_er   <= 1'b1;
        end
        default: begin
          tx_data <= '0;
          tx_en   <= 1'b0;
          tx_er   <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/mii_tx_path.sv
module mii_tx_path
  import mii_tx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_tx,
  input  logic              rst_n,
  input  logic              cfg_full_duplex,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_sof,
  input  logic              s_eof,
  input  logic              col_async,
  input  logic              crs_async,
  output logic [NIB_W-1:0]  tx_data,
  output logic              tx_en,
  output logic              tx_er
);
  localparam int LINE_INS = 2;

  logic [LINE_INS-1:0] line_sync;
  logic                col_s, crs_s, hold_now;
  logic                start_fire, data_accept;
  nib_op_e             op;

  mii_tx_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINE_INS)) u_sync (
    .clk     (clk_tx),
    .rst_n   (rst_n),
    .d_async ({crs_async, col_async}),
    .q_sync  (line_sync)
  );

  assign col_s    = line_sync[0];
  assign crs_s    = line_sync[1];
  assign hold_now = hold_start(cfg_full_duplex, col_s, crs_s);

  mii_tx_ctrl u_ctrl (
    .clk         (clk_tx),
    .rst_n       (rst_n),
    .hold        (hold_now),
    .s_valid     (s_valid),
    .s_sof       (s_sof),
    .s_eof       (s_eof),
    .line_en     (tx_en),
    .s_ready     (s_ready),
    .op          (op),
    .start_fire  (start_fire),
    .data_accept (data_accept)
  );

  mii_tx_nibble u_nib (
    .clk     (clk_tx),
    .rst_n   (rst_n),
    .op      (op),
    .in_byte (s_data),
    .tx_data (tx_data),
    .tx_en   (tx_en),
    .tx_er   (tx_er)
  );

  // R3: nothing on the data or error lines while enable is low
  assert_quiet_when_idle_R3: assert property (@(posedge clk_tx) disable iff (!rst_n)
    !tx_en |-> (tx_data == '0) && !tx_er);

  // R9: an error cycle carries enable and an all-zero nibble
  assert_error_shape_R9: assert property (@(posedge clk_tx) disable iff (!rst_n)
    tx_er |-> tx_en && (tx_data == '0));

  // R5: a frame begins only after a cycle in which starts were not held
  assert_no_start_when_held_R5: assert property (@(posedge clk_tx) disable iff (!rst_n)
    $rose(tx_en) |-> $past(!hold_now));
endmodule

// File: tb/mii_tx_path_tb.sv
module mii_tx_path_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_fd = 1'b1;
  logic       s_valid = 1'b0;
  logic       s_ready;
  logic [7:0] s_data = '0;
  logic       s_sof = 1'b0;
  logic       s_eof = 1'b0;
  logic       col = 1'b0;
  logic       crs = 1'b0;
  logic [3:0] tx_data;
  logic       tx_en;
  logic       tx_er;

  always #10 clk = ~clk;

  mii_tx_path u_dut (
    .clk_tx(clk), .rst_n(rst_n), .cfg_full_duplex(cfg_fd),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_sof(s_sof), .s_eof(s_eof), .col_async(col), .crs_async(crs),
    .tx_data(tx_data), .tx_en(tx_en), .tx_er(tx_er)
  );

  typedef struct { logic [3:0] nib; logic sof; } exp_t;
  exp_t exp_q[$];
  exp_t e;

  int n_cmp = 0, n_bad = 0;
  int rise_count = 0, err_seen = 0, low_run = 0, last_gap = 0;
  bit prev_en = 1'b0, err_ok = 1'b0, mon_on = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Monitor: pops the scoreboard as nibbles appear.
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      if (tx_en) begin
        if (!prev_en) begin
          rise_count++;
          last_gap = low_run;
        end
        if (tx_er) begin
          err_seen++;
          check(err_ok && tx_data == 4'h0, "R9", "error cycle nibble/permission",
                tx_data, 0);
        end else if (exp_q.size() == 0) begin
          check(1'b0, "R2", "unexpected nibble", tx_data, -1);
        end else begin
          e = exp_q.pop_front();
          check(tx_data == e.nib, "R2", "nibble value", tx_data, e.nib);
          check(!prev_en == e.sof, "R2", "frame start alignment", !prev_en, e.sof);
        end
        low_run = 0;
      end else begin
        check(tx_data == 4'h0 && !tx_er, "R3", "idle line quiet",
              {tx_er, tx_data}, 0);
        low_run++;
      end
      prev_en = tx_en;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic push_byte(input logic [7:0] b, input logic f, input logic l);
    bit ok = 1'b0;
    s_valid = 1'b1; s_data = b; s_sof = f; s_eof = l;
    while (!ok) begin
      #1;
      ok = s_ready;
      @(negedge clk);
    end
    s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
  endtask

  task automatic send_frame(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = seed + 8'(i * 37);
      exp_q.push_back('{nib: b[3:0], sof: (i == 0)});
      exp_q.push_back('{nib: b[7:4], sof: 1'b0});
      push_byte(b, i == 0, i == n - 1);
    end
  endtask

  task automatic send_starved(input int n_head, input int gap, input int n_tail);
    for (int i = 0; i < n_head; i++) begin
      logic [7:0] b;
      b = 8'hA1 + 8'(i * 19);
      exp_q.push_back('{nib: b[3:0], sof: (i == 0)});
      exp_q.push_back('{nib: b[7:4], sof: 1'b0});
      push_byte(b, i == 0, 1'b0);
    end
    err_ok = 1'b1;
    repeat (gap) @(negedge clk);
    for (int i = 0; i < n_tail; i++) push_byte(8'h5C + 8'(i), 1'b0, i == n_tail - 1);
  endtask

  task automatic wait_quiet();
    int quiet = 0;
    while (quiet < 4) begin
      tick(1);
      if (!tx_en && exp_q.size() == 0) quiet++;
      else quiet = 0;
    end
  endtask

  task automatic run_tests();
    int r0;
    // R1: reset state
    tick(3);
    check(tx_en == 0 && tx_er == 0 && tx_data == 0, "R1", "outputs in reset",
          {tx_en, tx_er, tx_data}, 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    tick(3);
    check(tx_en == 0 && tx_er == 0 && tx_data == 0, "R1", "outputs after reset",
          {tx_en, tx_er, tx_data}, 0);

    // R2/R6: full duplex, col low, several frame lengths
    send_frame(6, 8'h3C);
    send_frame(1, 8'hF0);
    wait_quiet();
    check(exp_q.size() == 0, "R2", "all nibbles seen", exp_q.size(), 0);

    // R4/R6: back-to-back frames, one-cycle gap
    send_frame(3, 8'h12);
    send_frame(4, 8'h9E);
    wait_quiet();
    check(last_gap == 1, "R4", "inter-frame gap cycles", last_gap, 1);
    check(rise_count == 4, "R6", "frames started with col low", rise_count, 4);

    // R10: bytes without a start marker while idle are dropped
    r0 = rise_count;
    push_byte(8'h77, 1'b0, 1'b0);
    push_byte(8'h88, 1'b0, 1'b1);
    tick(6);
    check(rise_count == r0, "R10", "stray bytes produced a frame", rise_count, r0);

    // R5: col pauses new frames in full duplex
    col = 1'b1;
    tick(4);
    r0 = rise_count;
    fork send_frame(4, 8'h44); join_none
    tick(20);
    check(rise_count == r0, "R5", "frame started while paused", rise_count, r0);
    col = 1'b0;
    wait_quiet();
    check(rise_count == r0 + 1, "R5", "frame after pause released", rise_count, r0 + 1);

    // R5: col rising mid-frame does not cut the frame
    r0 = rise_count;
    fork send_frame(8, 8'h61); join_none
    while (!tx_en) tick(1);
    tick(2);
    col = 1'b1;
    wait_quiet();
    check(rise_count == r0 + 1 && exp_q.size() == 0, "R5", "in-flight frame intact",
          rise_count - r0, 1);
    col = 1'b0;
    tick(4);

    // R8: full duplex ignores crs
    crs = 1'b1;
    tick(4);
    r0 = rise_count;
    send_frame(2, 8'hC3);
    wait_quiet();
    check(rise_count == r0 + 1, "R8", "crs ignored in full duplex", rise_count, r0 + 1);

    // R7: half duplex defers on crs, two-flop latency
    cfg_fd = 1'b0;
    tick(4);
    r0 = rise_count;
    fork send_frame(3, 8'h2B); join_none
    tick(15);
    check(rise_count == r0, "R7", "frame started under carrier", rise_count, r0);
    crs = 1'b0;
    tick(2);
    check(rise_count == r0, "R7", "start before synchronizer latency", rise_count, r0);
    tick(1);
    check(rise_count == r0 + 1, "R7", "start on third edge", rise_count, r0 + 1);
    wait_quiet();

    // R8: half duplex ignores col
    col = 1'b1;
    tick(4);
    r0 = rise_count;
    send_frame(2, 8'hD5);
    wait_quiet();
    check(rise_count == r0 + 1, "R8", "col ignored in half duplex", rise_count, r0 + 1);
    col = 1'b0;
    cfg_fd = 1'b1;
    tick(4);

    // R9: underrun mid-frame
    err_seen = 0;
    send_starved(2, 5, 3);
    wait_quiet();
    err_ok = 1'b0;
    check(err_seen >= 5, "R9", "error cycles during underrun", err_seen, 5);
    check(exp_q.size() == 0 && !tx_en, "R9", "frame closed after end byte",
          exp_q.size(), 0);

    // R2: normal frame after underrun is clean
    send_frame(5, 8'h0F);
    wait_quiet();
    check(exp_q.size() == 0, "R2", "recovery frame complete", exp_q.size(), 0);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule